// File: doc/BRIEF.md
# Chained Frequency-Domain Beamforming Element

This block is one cell of a frequency-domain station beamformer. Each cell handles one antenna for one beam. Every cycle it may accept a channelized complex sample together with the index of its frequency channel. It looks up a complex steering weight for that channel in a private weight memory and multiplies the sample by that weight. It then adds the product to a partial beam sum that arrives from the upstream cell, and hands the new sum downstream.

Cells are cascaded, so the last cell of a chain outputs the finished beam for that channel. A beamformer for L antennas and J beams uses J·L cells, organised as J chains. Each weight normally encodes an amplitude and a linear phase ramp across frequency, of the form a·e^(j·2π·f·k·τ) for antenna k. The weights are computed off-block and loaded through a host write port. That port runs alongside the data path and never stalls it.

The first cell of a chain is built with a parameter that replaces the upstream sum by zero. The channel index and a valid flag travel with the data. On idle cycles the upstream sum passes through unchanged.

Top module: `bfe_element`

## Requirements
- R1: While `rst_n` is low and after its release, until data reaches the output, `out_valid` is 0 and both `out_sum_re`/`out_sum_im` and `out_chan` are 0.
- R2: For an accepted sample (`in_valid`=1), the output sum appears exactly 3 rising edges after the edge that samples the inputs. It equals the incoming sum plus the complex product of the sample and the weight.
- R3: The product is computed as re = s_re·w_re − s_im·w_im and im = s_re·w_im + s_im·w_re. Samples and weights are two's-complement signed and the product is kept at full precision. It is sign-extended to `SUM_W` before the add.
- R4: The weight used for a sample is the word stored at the address equal to that sample's `in_chan`. Each channel has its own independent word.
- R5: With `wr_en`=1 at a rising edge, the word {`wr_wgt_re`,`wr_wgt_im`} is stored at `wr_addr`. A sample sampled at a later edge with that channel uses the new word. A sample sampled at the same edge with the same channel uses the previous word. There is no stall or ready signal.
- R6: When `in_valid`=0, `out_valid` goes to 0 three edges later and the output sum equals the incoming sum of that cycle, unchanged.
- R7: `out_valid` and `out_chan` repeat `in_valid` and `in_chan` with a delay of exactly 3 rising edges.
- R8: When `CHAIN_POS` is `CHAIN_HEAD`, the incoming sum ports are ignored and treated as zero, on both valid and idle cycles.
- R9: The chain add wraps modulo 2^`SUM_W` and does not saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host weight write strobe |
| wr_addr | input | CH_W | Channel address of the weight word to write |
| wr_wgt_re | input | WGT_W | Weight real part, signed |
| wr_wgt_im | input | WGT_W | Weight imaginary part, signed |
| in_valid | input | 1 | Sample and incoming sum are valid |
| in_chan | input | CH_W | Frequency channel index of the sample |
| in_samp_re | input | SAMP_W | Sample real part, signed |
| in_samp_im | input | SAMP_W | Sample imaginary part, signed |
| in_sum_re | input | SUM_W | Incoming partial beam sum, real, signed |
| in_sum_im | input | SUM_W | Incoming partial beam sum, imaginary, signed |
| out_valid | output | 1 | Outgoing sum is valid |
| out_chan | output | CH_W | Channel index travelling with the outgoing sum |
| out_sum_re | output | SUM_W | Outgoing partial beam sum, real, signed |
| out_sum_im | output | SUM_W | Outgoing partial beam sum, imaginary, signed |

## Verification
Every output of this block is due exactly three rising edges after the edge that samples the matching inputs. This holds for the sum, the valid flag and the channel alike. Weight writes affect lookups from the next edge onward. The bench drives inputs on falling edges and computes the expected outputs on the spot from a shadow copy of the weight memory, read before that cycle's write is applied. It places the result in a four-slot ring and compares it with the ports at the falling edge three cycles later. Idle cycles, the head variant and a same-cycle write/lookup collision go through the same ring, so every check uses the same three-cycle timing.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

   typedef enum logic {
      CHAIN_LINK = 1'b0,
      CHAIN_HEAD = 1'b1
   } chain_pos_e;

   localparam int unsigned DEF_CH_W   = 10;
   localparam int unsigned DEF_SAMP_W = 8;
   localparam int unsigned DEF_WGT_W  = 12;
   localparam int unsigned DEF_SUM_W  = 24;
   localparam int unsigned PIPE_LAT   = 3;

endpackage

// File: rtl/bfe_weight_ram.sv
module bfe_weight_ram #(
   parameter int unsigned CH_W  = bfe_pkg::DEF_CH_W,
   parameter int unsigned WGT_W = bfe_pkg::DEF_WGT_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [CH_W-1:0]         wr_addr,
   input  logic signed [WGT_W-1:0] wr_re,
   input  logic signed [WGT_W-1:0] wr_im,
   input  logic [CH_W-1:0]         rd_addr,
   output logic signed [WGT_W-1:0] rd_re,
   output logic signed [WGT_W-1:0] rd_im
);
   localparam int unsigned DEPTH  = 1 << CH_W;
   localparam int unsigned WORD_W = 2 * WGT_W;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] q;

   // read-first: a same-edge write is not seen by the same-edge read
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= {wr_re, wr_im};
      q <= mem[rd_addr];
   end

   assign rd_re = $signed(q[WORD_W-1 -: WGT_W]);
   assign rd_im = $signed(q[WGT_W-1:0]);

   AST_WR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en, 2) && ($past(rd_addr, 1) == $past(wr_addr, 2)) &&
       !($past(wr_en, 1) && ($past(wr_addr, 1) == $past(wr_addr, 2))))
      |-> (q == {$past(wr_re, 2), $past(wr_im, 2)}))
      else $error("weight word not read back after write"); // R5

endmodule

// File: rtl/bfe_cmul.sv
module bfe_cmul #(
   parameter int unsigned SAMP_W = bfe_pkg::DEF_SAMP_W,
   parameter int unsigned WGT_W  = bfe_pkg::DEF_WGT_W,
   localparam int unsigned MW    = SAMP_W + WGT_W,
   localparam int unsigned PW    = MW + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [SAMP_W-1:0] s_re,
   input  logic signed [SAMP_W-1:0] s_im,
   input  logic signed [WGT_W-1:0]  w_re,
   input  logic signed [WGT_W-1:0]  w_im,
   output logic signed [PW-1:0]     p_re,
   output logic signed [PW-1:0]     p_im
);
   logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;

   assign m_rr = s_re * w_re;
   assign m_ii = s_im * w_im;
   assign m_ri = s_re * w_im;
   assign m_ir = s_im * w_re;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_re <= '0;
         p_im <= '0;
      end else begin
         p_re <= {m_rr[MW-1], m_rr} - {m_ii[MW-1], m_ii};
         p_im <= {m_ri[MW-1], m_ri} + {m_ir[MW-1], m_ir};
      end
   end

endmodule

// File: rtl/bfe_chain_add.sv
module bfe_chain_add #(
   parameter int unsigned PW    = 21,
   parameter int unsigned SUM_W = bfe_pkg::DEF_SUM_W,
   localparam int unsigned EXT  = SUM_W - PW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld,
   input  logic signed [SUM_W-1:0] base_re,
   input  logic signed [SUM_W-1:0] base_im,
   input  logic signed [PW-1:0]    p_re,
   input  logic signed [PW-1:0]    p_im,
   output logic signed [SUM_W-1:0] sum_re,
   output logic signed [SUM_W-1:0] sum_im
);
   logic [SUM_W-1:0] ext_re, ext_im;

   assign ext_re = {{EXT{p_re[PW-1]}}, p_re};
   assign ext_im = {{EXT{p_im[PW-1]}}, p_im};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_re <= '0;
         sum_im <= '0;
      end else if (vld) begin
         sum_re <= base_re + ext_re;
         sum_im <= base_im + ext_im;
      end else begin
         sum_re <= base_re;
         sum_im <= base_im;
      end
   end

endmodule

// File: rtl/bfe_element.sv
module bfe_element #(
   parameter int unsigned CH_W   = bfe_pkg::DEF_CH_W,
   parameter int unsigned SAMP_W = bfe_pkg::DEF_SAMP_W,
   parameter int unsigned WGT_W  = bfe_pkg::DEF_WGT_W,
   parameter int unsigned SUM_W  = bfe_pkg::DEF_SUM_W,
   parameter bfe_pkg::chain_pos_e CHAIN_POS = bfe_pkg::CHAIN_LINK
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [CH_W-1:0]          wr_addr,
   input  logic signed [WGT_W-1:0]  wr_wgt_re,
   input  logic signed [WGT_W-1:0]  wr_wgt_im,
   input  logic                     in_valid,
   input  logic [CH_W-1:0]          in_chan,
   input  logic signed [SAMP_W-1:0] in_samp_re,
   input  logic signed [SAMP_W-1:0] in_samp_im,
   input  logic signed [SUM_W-1:0]  in_sum_re,
   input  logic signed [SUM_W-1:0]  in_sum_im,
   output logic                     out_valid,
   output logic [CH_W-1:0]          out_chan,
   output logic signed [SUM_W-1:0]  out_sum_re,
   output logic signed [SUM_W-1:0]  out_sum_im
);
   localparam int unsigned PW = SAMP_W + WGT_W + 1;

   if (SUM_W <= PW) begin : g_bad_sum_w
      $error("SUM_W must exceed the full product width");
   end
   if (CH_W < 1 || CH_W > 16) begin : g_bad_ch_w
      $error("CH_W out of supported range");
   end
   if (SAMP_W < 2 || WGT_W < 2) begin : g_bad_data_w
      $error("sample and weight widths must be at least 2");
   end

   // incoming sum selection: head of chain starts from zero
   logic signed [SUM_W-1:0] base_re, base_im;
   if (CHAIN_POS == bfe_pkg::CHAIN_HEAD) begin : g_head
      assign base_re = '0;
      assign base_im = '0;
   end else begin : g_link
      assign base_re = in_sum_re;
      assign base_im = in_sum_im;
   end

   // stage 1: capture inputs while the weight is read
   logic                    v1, v2;
   logic [CH_W-1:0]         ch1, ch2;
   logic signed [SAMP_W-1:0] sr1, si1;
   logic signed [SUM_W-1:0] b1_re, b1_im, b2_re, b2_im;
   logic signed [WGT_W-1:0] w_re, w_im;
   logic signed [PW-1:0]    p_re, p_im;

   bfe_weight_ram #(.CH_W(CH_W), .WGT_W(WGT_W)) u_wram (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_re(wr_wgt_re), .wr_im(wr_wgt_im),
      .rd_addr(in_chan), .rd_re(w_re), .rd_im(w_im)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0;  ch1 <= '0;
         sr1 <= '0;   si1 <= '0;
         b1_re <= '0; b1_im <= '0;
      end else begin
         v1 <= in_valid; ch1 <= in_chan;
         sr1 <= in_samp_re; si1 <= in_samp_im;
         b1_re <= base_re;  b1_im <= base_im;
      end
   end

   // stage 2: complex multiply, sidebands follow
   bfe_cmul #(.SAMP_W(SAMP_W), .WGT_W(WGT_W)) u_cmul (
      .clk(clk), .rst_n(rst_n),
      .s_re(sr1), .s_im(si1), .w_re(w_re), .w_im(w_im),
      .p_re(p_re), .p_im(p_im)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2 <= 1'b0;  ch2 <= '0;
         b2_re <= '0; b2_im <= '0;
      end else begin
         v2 <= v1;       ch2 <= ch1;
         b2_re <= b1_re; b2_im <= b1_im;
      end
   end

   // stage 3: chained add
   bfe_chain_add #(.PW(PW), .SUM_W(SUM_W)) u_add (
      .clk(clk), .rst_n(rst_n), .vld(v2),
      .base_re(b2_re), .base_im(b2_im), .p_re(p_re), .p_im(p_im),
      .sum_re(out_sum_re), .sum_im(out_sum_im)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= '0;
      end else begin
         out_valid <= v2;
         out_chan  <= ch2;
      end
   end

   // cycles since reset, so that 3-deep history checks only see post-reset inputs
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)         age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3)))
      else $error("valid latency broken"); // R7

   AST_CHAN_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_chan == $past(in_chan, 3)))
      else $error("channel misaligned"); // R7

   if (CHAIN_POS == bfe_pkg::CHAIN_HEAD) begin : g_ast_head
      AST_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         ((age == 2'd3) && !out_valid) |-> ((out_sum_re == '0) && (out_sum_im == '0)))
         else $error("head element leaked an incoming sum"); // R8
   end else begin : g_ast_link
      AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         ((age == 2'd3) && !out_valid) |->
         ((out_sum_re == $past(in_sum_re, 3)) && (out_sum_im == $past(in_sum_im, 3))))
         else $error("idle cycle altered the sum"); // R6
   end

endmodule

// File: tb/tb_bfe_element.sv
module tb_bfe_element;
   localparam int CH_W = 10, SAMP_W = 8, WGT_W = 12, SUM_W = 24;
   localparam int NCH = 1 << CH_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              wr_en = 1'b0;
   logic [CH_W-1:0]   wr_addr = '0;
   logic [WGT_W-1:0]  wr_wgt_re = '0, wr_wgt_im = '0;
   logic              in_valid = 1'b0;
   logic [CH_W-1:0]   in_chan = '0;
   logic [SAMP_W-1:0] in_samp_re = '0, in_samp_im = '0;
   logic [SUM_W-1:0]  in_sum_re = '0, in_sum_im = '0;

   logic              o_v, h_v;
   logic [CH_W-1:0]   o_ch, h_ch;
   logic [SUM_W-1:0]  o_re, o_im, h_re, h_im;

   bfe_element #(.CH_W(CH_W), .SAMP_W(SAMP_W), .WGT_W(WGT_W), .SUM_W(SUM_W),
                 .CHAIN_POS(bfe_pkg::CHAIN_LINK)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_wgt_re(wr_wgt_re), .wr_wgt_im(wr_wgt_im),
      .in_valid(in_valid), .in_chan(in_chan),
      .in_samp_re(in_samp_re), .in_samp_im(in_samp_im),
      .in_sum_re(in_sum_re), .in_sum_im(in_sum_im),
      .out_valid(o_v), .out_chan(o_ch), .out_sum_re(o_re), .out_sum_im(o_im));

   bfe_element #(.CH_W(CH_W), .SAMP_W(SAMP_W), .WGT_W(WGT_W), .SUM_W(SUM_W),
                 .CHAIN_POS(bfe_pkg::CHAIN_HEAD)) dut_head (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_wgt_re(wr_wgt_re), .wr_wgt_im(wr_wgt_im),
      .in_valid(in_valid), .in_chan(in_chan),
      .in_samp_re(in_samp_re), .in_samp_im(in_samp_im),
      .in_sum_re(in_sum_re), .in_sum_im(in_sum_im),
      .out_valid(h_v), .out_chan(h_ch), .out_sum_re(h_re), .out_sum_im(h_im));

   int checks = 0, fails = 0, cyc = 0, edges = 0;
   int sh_re [NCH];
   int sh_im [NCH];

   // expectation ring: slot written at step k is checked at step k+3
   bit               e_chk [4];
   bit               e_v   [4];
   logic [CH_W-1:0]  e_ch  [4];
   logic [SUM_W-1:0] e_re [4], e_im [4], e_hre [4], e_him [4];
   string            e_tag [4];

   function automatic int rs(int w);
      return int'($urandom % (32'd1 << w)) - (1 << (w - 1));
   endfunction

   function automatic int prod_re(int sr, int si, int wr, int wi);
      return sr * wr - si * wi; // R3
   endfunction
   function automatic int prod_im(int sr, int si, int wr, int wi);
      return sr * wi + si * wr; // R3
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      edges++;
      if (edges > 100000) begin
         fails++;
         $display("FAIL watchdog R2 actual=%0d edges expected=completion", edges);
         summary();
         $finish;
      end
   end

   task automatic compare_slot(int s);
      bit bad = 0;
      checks++;
      if (o_v !== e_v[s] || h_v !== e_v[s]) begin
         bad = 1;
         $display("FAIL R7 valid actual=%0b/%0b expected=%0b (%s)", o_v, h_v, e_v[s], e_tag[s]);
      end
      if (o_ch !== e_ch[s] || h_ch !== e_ch[s]) begin
         bad = 1;
         $display("FAIL R7 chan actual=%0d/%0d expected=%0d (%s)", o_ch, h_ch, e_ch[s], e_tag[s]);
      end
      if (o_re !== e_re[s] || o_im !== e_im[s]) begin
         bad = 1;
         $display("FAIL %s sum actual=%h/%h expected=%h/%h", e_tag[s], o_re, o_im, e_re[s], e_im[s]);
      end
      if (h_re !== e_hre[s] || h_im !== e_him[s]) begin
         bad = 1;
         $display("FAIL R8 head sum actual=%h/%h expected=%h/%h (%s)", h_re, h_im, e_hre[s], e_him[s], e_tag[s]);
      end
      if (bad) fails++;
   endtask

   task automatic step(bit v, int ch, int sr, int si, int psr, int psi,
                       bit we, int wa, int wwr, int wwi, string tag);
      int s, pre, pim;
      @(negedge clk);
      s = (cyc + 1) % 4;
      if (e_chk[s]) compare_slot(s);
      in_valid = v; in_chan = CH_W'(ch);
      in_samp_re = SAMP_W'(sr); in_samp_im = SAMP_W'(si);
      in_sum_re = SUM_W'(psr);  in_sum_im = SUM_W'(psi);
      wr_en = we; wr_addr = CH_W'(wa);
      wr_wgt_re = WGT_W'(wwr); wr_wgt_im = WGT_W'(wwi);
      s = cyc % 4;
      pre = v ? prod_re(sr, si, sh_re[ch], sh_im[ch]) : 0; // R4: weight by channel
      pim = v ? prod_im(sr, si, sh_re[ch], sh_im[ch]) : 0;
      e_chk[s] = 1; e_v[s] = v; e_ch[s] = CH_W'(ch);
      e_re[s]  = SUM_W'(psr + pre); e_im[s] = SUM_W'(psi + pim); // R9 wrap by truncation
      e_hre[s] = SUM_W'(pre);       e_him[s] = SUM_W'(pim);
      e_tag[s] = tag;
      if (we) begin sh_re[wa] = wwr; sh_im[wa] = wwi; end // read-first: after lookup
      cyc++;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) begin
         e_chk[i] = 1; e_v[i] = 0; e_ch[i] = '0;
         e_re[i] = '0; e_im[i] = '0; e_hre[i] = '0; e_him[i] = '0; e_tag[i] = "R1";
      end
      for (int i = 0; i < NCH; i++) begin sh_re[i] = 0; sh_im[i] = 0; end

      // R1: outputs during reset
      repeat (4) @(negedge clk);
      checks++;
      if (o_v !== 1'b0 || o_re !== '0 || o_im !== '0 || o_ch !== '0 || h_v !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset actual=%0b/%h/%h/%0d expected=0/0/0/0", o_v, o_re, o_im, o_ch);
      end
      @(negedge clk); rst_n = 1'b1;

      // load every weight while idle cycles carry random sums (R5, R6)
      for (int a = 0; a < NCH; a++)
         step(0, a, rs(8), rs(8), rs(24), rs(24), 1, a, rs(12), rs(12), "R6");
      // directed extreme weights
      step(0, 0, 0, 0, 0, 0, 1, 0, -2048, -2048, "R6");
      step(0, 0, 0, 0, 0, 0, 1, 1, 2047, -2048, "R6");
      step(0, 0, 0, 0, 0, 0, 1, 2, 2047, 0, "R6");
      // R3: extreme products
      step(1, 0, -128, -128, 0, 0, 0, 0, 0, 0, "R3");
      step(1, 1, 127, -128, 0, 0, 0, 0, 0, 0, "R3");
      step(1, 1, -128, 127, 100, -100, 0, 0, 0, 0, "R3");
      // R9: wrap past the positive limit and past the negative limit
      step(1, 2, 127, 0, 8388607, -8388608, 0, 0, 0, 0, "R9");
      step(1, 2, -128, -128, -8388608, 8388607, 0, 0, 0, 0, "R9");
      // R4: walk consecutive channels with the same sample
      for (int c = 0; c < 16; c++) step(1, c, 77, -33, c * 1000, -c, 0, 0, 0, 0, "R4");
      // R5: same-edge write and lookup of channel 5 sees old word, next sees new
      step(1, 5, 50, 60, 0, 0, 1, 5, 1234, -777, "R5");
      step(1, 5, 50, 60, 0, 0, 0, 0, 0, 0, "R5");
      step(1, 5, -9, 3, 7, 7, 1, 6, -1, 1, "R5");
      idle(4);
      // R2: random stream mixed with idle cycles and concurrent writes
      for (int i = 0; i < 3000; i++) begin
         bit v  = ($urandom % 4) != 0;
         bit we = ($urandom % 10) == 0;
         step(v, int'($urandom % NCH), rs(8), rs(8), rs(24), rs(24),
              we, int'($urandom % NCH), rs(12), rs(12), v ? "R2" : "R6");
      end
      idle(4);
      summary();
      $finish;
   end

endmodule